// File: doc/BRIEF.md
# Passive Serial Configuration Host

This block loads a bitstream into a target programmable device over a one-wire serial data path that has a separate clock. When `start_i` is asserted, it drives the target's active-low configuration request low for a minimum time and then releases it. It then waits for the target's active-low status line to go high. After that it shifts bytes taken from an upstream valid/ready stream out onto `data_o`, one bit per serial clock period, with the least-significant bit first.

After the byte marked last has been sent, the block checks the target's done and init-done inputs. The target can report an error by pulling the status line low, and a done or init-done input can fail to rise in time. In either case the block makes another attempt, up to a parameterised limit. Two retry modes exist. In one, the block waits for the target to release the status line by itself. In the other, it issues a fresh configuration request pulse. When configuration ends, the serial clock and data are parked low. A new start request can be made from the finished or failed state. The upstream source must restart its stream from the first byte whenever `tries_o` changes or `start_i` is pulsed.

Top module: `ps_cfg_host`

## Requirements
- R1: After reset, `cfg_n_o` is 1 and `dclk_o`, `data_o`, `busy_o`, `done_o`, `error_o`, `s_ready_o` and `tries_o` are all 0.
- R2: A start request drives `cfg_n_o` low for at least PULSE_MS × TICKS_PER_MS clock cycles and then high again. It sets `tries_o` to 1 and raises `busy_o`.
- R3: No stream byte is accepted while `status_n_i` is low. If the status line stays low for TIMEOUT_MS after the request pulse, the block enters the failed state (`error_o` = 1) with no retry.
- R4: Each byte is sent least-significant bit first. Each bit holds `dclk_o` low for CLK_DIV cycles and then high for CLK_DIV cycles. `data_o` changes only while `dclk_o` is low, so the target samples it on the rising edge.
- R5: While no byte is offered, `dclk_o` stays low indefinitely. Shifting resumes later with no lost or repeated bit.
- R6: If `status_n_i` goes low during shifting, the attempt is aborted. With `auto_restart_i` = 1, the block reloads without a new request pulse once status rises. With `auto_restart_i` = 0, it issues a new request pulse first. Either way `tries_o` increments.
- R7: After the last bit, the attempt succeeds only if `done_i` and then `init_done_i` both rise, each within TIMEOUT_MS. Otherwise the attempt counts as failed and is retried.
- R8: Once MAX_TRIES attempts have failed, the block stops in the failed state with `error_o` = 1 and `tries_o` = MAX_TRIES. `tries_o` never exceeds MAX_TRIES.
- R9: On success, `done_o` = 1 and `busy_o` = 0, and `dclk_o` and `data_o` are held at 0. At most one of `busy_o`, `done_o` and `error_o` is high at a time.
- R10: A start request in the finished or failed state begins a new load with a new request pulse, and `tries_o` is reset to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start or reconfigure request |
| auto_restart_i | input | 1 | 1: wait for status release on retry; 0: pulse the request line again |
| s_valid_i | input | 1 | Upstream byte valid |
| s_data_i | input | BYTE_W | Upstream byte |
| s_last_i | input | 1 | Marks the final byte of the bitstream |
| s_ready_o | output | 1 | Byte accepted when high together with valid |
| status_n_i | input | 1 | Target status, active low |
| done_i | input | 1 | Target configuration-done |
| init_done_i | input | 1 | Target initialisation-done |
| cfg_n_o | output | 1 | Configuration request, active low |
| dclk_o | output | 1 | Serial clock to target |
| data_o | output | 1 | Serial data to target |
| busy_o | output | 1 | A load is in progress |
| done_o | output | 1 | Target configured and in user mode |
| error_o | output | 1 | Load abandoned |
| tries_o | output | TRY_W | Attempts used in the current load |

## Verification
The hardest case to reach from the ports is an error report that arrives in the middle of a byte, at a chosen bit of a chosen attempt, while upstream is also stalling. That error must then be followed by a clean reload in both retry modes. The bench's model of the target counts the bits it samples on rising serial clock edges. It pulls the status line low at a randomly chosen bit position for a programmed number of attempts, and releases it a few cycles later. Random runs combine this with random stall rates, image sizes, retry modes and done or init-done failures. Each run's expected attempt count, number of request pulses and final flag are computed from these settings.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ_PULSE,
    ST_AWAIT_STATUS,
    ST_STREAM,
    ST_AWAIT_DONE,
    ST_AWAIT_INIT,
    ST_RUNNING,
    ST_FAILED
  } cfg_state_e;
endpackage

// File: rtl/ps_ms_timer.sv
module ps_ms_timer #(
  parameter int TICKS_PER_MS = 1000,
  parameter int MS_W         = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear_i,
  output logic [MS_W-1:0] ms_o
);
  localparam int TW = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;

  logic [TW-1:0] tick_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      tick_q <= '0;
      ms_o   <= '0;
    end else if (tick_q == TW'(TICKS_PER_MS - 1)) begin
      tick_q <= '0;
      if (ms_o != '1) ms_o <= ms_o + MS_W'(1);
    end else begin
      tick_q <= tick_q + TW'(1);
    end
  end
endmodule

// File: rtl/ps_bit_shifter.sv
module ps_bit_shifter #(
  parameter int CLK_DIV = 2,
  parameter int BYTE_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active_i,
  input  logic              s_valid_i,
  input  logic [BYTE_W-1:0] s_data_i,
  input  logic              s_last_i,
  output logic              s_ready_o,
  output logic              dclk_o,
  output logic              data_o,
  output logic              fin_o
);
  localparam int PW = (2 * CLK_DIV > 1) ? $clog2(2 * CLK_DIV) : 1;
  localparam int BW = $clog2(BYTE_W);

  logic [BYTE_W-1:0] sh_q;
  logic [PW-1:0]     phase_q;
  logic [BW-1:0]     bit_q;
  logic              full_q;
  logic              last_q;
  logic              ended_q;

  assign s_ready_o = active_i && !full_q && !ended_q;

  always_ff @(posedge clk) begin
    if (rst || !active_i) begin
      sh_q    <= '0;
      phase_q <= '0;
      bit_q   <= '0;
      full_q  <= 1'b0;
      last_q  <= 1'b0;
      ended_q <= 1'b0;
      dclk_o  <= 1'b0;
      data_o  <= 1'b0;
      fin_o   <= 1'b0;
    end else if (!full_q) begin
      fin_o <= 1'b0;
      if (s_valid_i && !ended_q) begin
        sh_q    <= s_data_i;
        data_o  <= s_data_i[0];
        last_q  <= s_last_i;
        bit_q   <= '0;
        phase_q <= '0;
        full_q  <= 1'b1;
      end
    end else if (phase_q == PW'(2 * CLK_DIV - 1)) begin
      phase_q <= '0;
      dclk_o  <= 1'b0;
      if (bit_q == BW'(BYTE_W - 1)) begin
        full_q <= 1'b0;
        if (last_q) begin
          ended_q <= 1'b1;
          fin_o   <= 1'b1;
        end
      end else begin
        bit_q  <= bit_q + BW'(1);
        sh_q   <= sh_q >> 1;
        data_o <= sh_q[1];
      end
    end else begin
      phase_q <= phase_q + PW'(1);
      if (phase_q == PW'(CLK_DIV - 1)) dclk_o <= 1'b1;
    end
  end
endmodule

// File: rtl/ps_cfg_host.sv
module ps_cfg_host
  import ps_cfg_pkg::*;
#(
  parameter int TICKS_PER_MS = 50000,
  parameter int PULSE_MS     = 2,
  parameter int TIMEOUT_MS   = 100,
  parameter int MAX_TRIES    = 4,
  parameter int CLK_DIV      = 4,
  parameter int BYTE_W       = 8,
  localparam int TRY_W       = $clog2(MAX_TRIES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              auto_restart_i,
  input  logic              s_valid_i,
  input  logic [BYTE_W-1:0] s_data_i,
  input  logic              s_last_i,
  output logic              s_ready_o,
  input  logic              status_n_i,
  input  logic              done_i,
  input  logic              init_done_i,
  output logic              cfg_n_o,
  output logic              dclk_o,
  output logic              data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o,
  output logic [TRY_W-1:0]  tries_o
);
  localparam int MS_W = $clog2(TIMEOUT_MS + PULSE_MS + 1) + 1;

  cfg_state_e      state_q, state_d;
  logic [MS_W-1:0] ms_w;
  logic            fin_w;
  logic            fail_w;
  logic            pulse_over, wait_over;

  assign pulse_over = (ms_w >= MS_W'(PULSE_MS));
  assign wait_over  = (ms_w >= MS_W'(TIMEOUT_MS));

  ps_ms_timer #(.TICKS_PER_MS(TICKS_PER_MS), .MS_W(MS_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clear_i(state_d != state_q),
    .ms_o   (ms_w)
  );

  ps_bit_shifter #(.CLK_DIV(CLK_DIV), .BYTE_W(BYTE_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .active_i (state_q == ST_STREAM),
    .s_valid_i(s_valid_i),
    .s_data_i (s_data_i),
    .s_last_i (s_last_i),
    .s_ready_o(s_ready_o),
    .dclk_o   (dclk_o),
    .data_o   (data_o),
    .fin_o    (fin_w)
  );

  always_comb begin
    state_d = state_q;
    fail_w  = 1'b0;
    case (state_q)
      ST_IDLE, ST_RUNNING, ST_FAILED:
        if (start_i) state_d = ST_REQ_PULSE;
      ST_REQ_PULSE:
        if (pulse_over) state_d = ST_AWAIT_STATUS;
      ST_AWAIT_STATUS:
        if (status_n_i)     state_d = ST_STREAM;
        else if (wait_over) state_d = ST_FAILED;
      ST_STREAM:
        if (!status_n_i) fail_w  = 1'b1;
        else if (fin_w)  state_d = ST_AWAIT_DONE;
      ST_AWAIT_DONE:
        if (done_i)         state_d = ST_AWAIT_INIT;
        else if (wait_over) fail_w  = 1'b1;
      ST_AWAIT_INIT:
        if (done_i && init_done_i) state_d = ST_RUNNING;
        else if (wait_over)        fail_w  = 1'b1;
      default: state_d = ST_IDLE;
    endcase
    if (fail_w) begin
      if (tries_o >= TRY_W'(MAX_TRIES)) state_d = ST_FAILED;
      else if (auto_restart_i)          state_d = ST_AWAIT_STATUS;
      else                              state_d = ST_REQ_PULSE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      tries_o <= '0;
      cfg_n_o <= 1'b1;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      error_o <= 1'b0;
    end else begin
      state_q <= state_d;
      if ((state_q == ST_IDLE || state_q == ST_RUNNING || state_q == ST_FAILED)
          && state_d == ST_REQ_PULSE)
        tries_o <= TRY_W'(1);
      else if (fail_w && state_d != ST_FAILED)
        tries_o <= tries_o + TRY_W'(1);
      cfg_n_o <= (state_d != ST_REQ_PULSE);
      busy_o  <= (state_d == ST_REQ_PULSE) || (state_d == ST_AWAIT_STATUS) ||
                 (state_d == ST_STREAM) || (state_d == ST_AWAIT_DONE) ||
                 (state_d == ST_AWAIT_INIT);
      done_o  <= (state_d == ST_RUNNING);
      error_o <= (state_d == ST_FAILED);
    end
  end
endmodule

// File: rtl/ps_cfg_host_chk.sv
module ps_cfg_host_chk #(
  parameter int MIN_LOW   = 8,
  parameter int MAX_TRIES = 4,
  parameter int TRY_W     = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_n_o,
  input logic             s_ready_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             error_o,
  input logic             dclk_o,
  input logic             data_o,
  input logic [TRY_W-1:0] tries_o
);
  int low_run;

  always_ff @(posedge clk) begin
    if (rst || cfg_n_o) low_run <= 0;
    else if (low_run < MIN_LOW) low_run <= low_run + 1;
  end

  AST_REQ_PULSE_LEN: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_n_o) |-> (low_run >= MIN_LOW)); // R2
  AST_READY_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    s_ready_o |-> busy_o); // R3
  AST_DATA_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (dclk_o && $past(dclk_o)) |-> $stable(data_o)); // R4
  AST_TRIES_CAP: assert property (@(posedge clk) disable iff (rst)
    tries_o <= TRY_W'(MAX_TRIES)); // R8
  AST_PARKED_WHEN_DONE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!dclk_o && !data_o)); // R9
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({busy_o, done_o, error_o})); // R9
endmodule

bind ps_cfg_host ps_cfg_host_chk #(
  .MIN_LOW  (PULSE_MS * TICKS_PER_MS),
  .MAX_TRIES(MAX_TRIES),
  .TRY_W    (TRY_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_n_o  (cfg_n_o),
  .s_ready_o(s_ready_o),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .error_o  (error_o),
  .dclk_o   (dclk_o),
  .data_o   (data_o),
  .tries_o  (tries_o)
);

// File: tb/ps_cfg_host_test.sv
module ps_cfg_host_test;
  localparam int TPM = 4, PMS = 2, TMS = 6, MAXT = 3, DIV = 2, BW = 8;
  localparam int MIN_LOW = PMS * TPM;
  localparam int TRY_W = $clog2(MAXT + 1);

  logic clk = 0, rst = 1;
  logic start_i = 0, auto_restart_i = 0;
  logic s_valid_i, s_last_i, s_ready_o;
  logic [BW-1:0] s_data_i;
  logic status_n_i, done_i, init_done_i;
  logic cfg_n_o, dclk_o, data_o, busy_o, done_o, error_o;
  logic [TRY_W-1:0] tries_o;

  ps_cfg_host #(.TICKS_PER_MS(TPM), .PULSE_MS(PMS), .TIMEOUT_MS(TMS),
                .MAX_TRIES(MAXT), .CLK_DIV(DIV), .BYTE_W(BW)) uut (.*);

  always #2 clk = ~clk;

  int vectors = 0, miscompares = 0, cycles = 0;
  logic [7:0] img [0:15];
  int total_bytes = 1, idx, stall_pct = 0;
  int m_fail_at = 0, m_fails_left = 0, rel, nbits;
  bit m_good_done = 1, m_good_init = 1, m_stuck = 0;
  logic dclk_prev;
  logic [TRY_W-1:0] drv_last_tries, m_last_tries;
  int bit_err = 0, pulses = 0, bad_pulse = 0, low_w = 0, ready_viol = 0;
  int hi_run = 0, bad_hi = 0;
  logic cfg_prev = 1, st_prev = 1, dclk_s = 0;

  assign s_data_i = img[idx[3:0]];
  assign s_last_i = (idx == total_bytes - 1);

  // upstream stream source, restarts on each new attempt
  always @(posedge clk) begin
    if (rst) begin
      idx <= 0; s_valid_i <= 0; drv_last_tries <= '0;
    end else begin
      drv_last_tries <= tries_o;
      if (start_i || tries_o != drv_last_tries) begin
        idx <= 0; s_valid_i <= 0;
      end else begin
        if (s_valid_i && s_ready_o) idx <= idx + 1;
        s_valid_i <= ($urandom_range(99) >= stall_pct);
      end
    end
  end

  // target model
  always @(posedge clk) begin
    dclk_prev <= dclk_o;
    m_last_tries <= tries_o;
    if (rst) begin
      status_n_i <= 1; done_i <= 0; init_done_i <= 0; rel <= 0; nbits <= 0;
    end else if (!cfg_n_o) begin
      status_n_i <= 0; rel <= 3; nbits <= 0; done_i <= 0; init_done_i <= 0;
    end else if (m_stuck) begin
      status_n_i <= 0;
    end else if (rel > 1) begin
      rel <= rel - 1;
    end else if (rel == 1) begin
      status_n_i <= 1; rel <= 0;
    end else begin
      if (tries_o != m_last_tries) nbits <= 0;
      else if (dclk_o && !dclk_prev) begin
        if (nbits >= total_bytes * 8) bit_err <= bit_err + 1;
        else if (data_o !== img[nbits / 8][nbits % 8]) bit_err <= bit_err + 1;
        if (m_fails_left > 0 && nbits + 1 == m_fail_at) begin
          status_n_i <= 0; rel <= 5; nbits <= 0; m_fails_left <= m_fails_left - 1;
        end else nbits <= nbits + 1;
      end
      if (status_n_i && nbits == total_bytes * 8 && m_good_done) done_i <= 1;
      if (done_i && m_good_init) init_done_i <= 1;
    end
  end

  // port monitors sampled away from the active edge
  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (!rst) begin
      if (cfg_prev && !cfg_n_o) begin pulses <= pulses + 1; low_w <= 1; end
      else if (!cfg_n_o) low_w <= low_w + 1;
      else if (!cfg_prev && low_w < MIN_LOW) bad_pulse <= bad_pulse + 1;
      if (s_ready_o && !status_n_i && !st_prev) ready_viol <= ready_viol + 1;
      if (dclk_o) hi_run <= hi_run + 1;
      else begin
        if (dclk_s && hi_run != DIV) bad_hi <= bad_hi + 1;
        hi_run <= 0;
      end
    end
    cfg_prev <= cfg_n_o; st_prev <= status_n_i; dclk_s <= dclk_o;
  end

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_tries(int fails, bit gd, bit gi, bit stuck);
    if (stuck) return 1;
    if (!gd || !gi) return MAXT;
    return (fails < MAXT) ? fails + 1 : MAXT;
  endfunction

  task automatic run_case(int nb, int stall, bit autom, int fails, bit gd, bit gi, bit stuck);
    int guard = 0;
    bit ok;
    int et;
    @(negedge clk);
    total_bytes = nb; stall_pct = stall; auto_restart_i = autom;
    for (int i = 0; i < 16; i++) img[i] = 8'($urandom);
    m_fail_at = $urandom_range(nb * 8, 1); m_fails_left = fails;
    m_good_done = gd; m_good_init = gi; m_stuck = stuck;
    bit_err = 0; pulses = 0; bad_pulse = 0; ready_viol = 0; bad_hi = 0;
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    chk("R2 busy after start", int'(busy_o), 1);
    while (!(done_o || error_o) && guard < 20000) begin
      @(negedge clk); guard++;
    end
    if (guard >= 20000) chk("watchdog case", 0, 1);
    ok = gd && gi && !stuck && fails < MAXT;
    et = exp_tries(fails, gd, gi, stuck);
    chk("R9/R8 done flag", int'(done_o), int'(ok));
    chk("R8/R3 error flag", int'(error_o), int'(!ok));
    chk("R10/R6/R8 tries", int'(tries_o), et);
    chk("R6 request pulses", pulses, (stuck || autom) ? 1 : et);
    chk("R2 pulse width", bad_pulse, 0);
    chk("R3 ready while status low", ready_viol, 0);
    chk("R4/R5 bit errors", bit_err, 0);
    chk("R4 clock high width", bad_hi, 0);
    if (ok) begin
      chk("R9 dclk parked", int'(dclk_o), 0);
      chk("R9 data parked", int'(data_o), 0);
      chk("R7 all bits seen", nbits, nb * 8);
    end
    m_stuck = 0;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) img[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 cfg_n", int'(cfg_n_o), 1);
    chk("R1 dclk", int'(dclk_o), 0);
    chk("R1 data", int'(data_o), 0);
    chk("R1 flags", int'({busy_o, done_o, error_o}), 0);
    chk("R1 ready", int'(s_ready_o), 0);
    chk("R1 tries", int'(tries_o), 0);
    run_case(3, 0, 0, 0, 1, 1, 0);   // plain load
    run_case(4, 70, 1, 0, 1, 1, 0);  // R5 heavy stalls
    run_case(2, 20, 0, 1, 1, 1, 0);  // R6 manual retry
    run_case(3, 30, 1, 2, 1, 1, 0);  // R6 auto retry twice
    run_case(1, 0, 0, 3, 1, 1, 0);   // R8 exhaust manual
    run_case(2, 0, 1, 0, 0, 1, 0);   // R7 done missing
    run_case(2, 0, 0, 0, 1, 0, 0);   // R7 init-done missing
    run_case(1, 0, 0, 0, 1, 1, 1);   // R3 status never released
    run_case(2, 10, 0, 0, 1, 1, 0);  // R10 restart from failed
    for (int k = 0; k < 30; k++)
      run_case($urandom_range(6, 1), $urandom_range(80), 1'($urandom),
               $urandom_range(3), ($urandom_range(9) != 0), ($urandom_range(9) != 0), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > 190000) begin
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule